// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block caches recent address translations for a processor's memory pipeline. Each entry holds a virtual page number, the process identifier that owns it, the physical page number it maps to and a small set of access-right bits. A lookup presents a virtual page number, the current process identifier and whether the access is a write. Every stored entry is compared against that pair at once, and the answer appears one clock later: a hit with the physical page and rights, a protection fault, or a miss.

Translations arrive on a fill port from a page walker outside this block. A fill that names a pair already present rewrites that entry in place. Otherwise it takes the lowest-numbered empty entry, or the entry under a round-robin replacement pointer when every entry is in use. Two invalidation commands keep the contents coherent with the page tables. One removes the entry for a single page of a single process. The other empties the whole buffer. Because entries carry the process identifier, a context switch needs neither command.

Top module: `tlbx_top`

## Requirements
- R1: After reset no entry is valid, the replacement pointer is at entry 0, `rsp_valid` is low, and every lookup misses.
- R2: A lookup presented in one cycle is answered in the next cycle with `rsp_valid` high, and `rsp_valid` is low in a cycle that follows no lookup. A lookup sees the contents as they stood before any fill or invalidation in the same cycle.
- R3: A lookup hits only when a valid entry matches both the virtual page number and the process identifier. A hit returns that entry's physical page number and access-right bits.
- R4: Entries for the same virtual page under different process identifiers coexist, and each returns its own physical page. A lookup under a process identifier with no entry for that page misses.
- R5: Access-right bit 1 is the write permission. A write lookup that matches an entry with bit 1 clear gives `rsp_fault`=1 and `rsp_hit`=0. A read lookup of that entry, or a write lookup of an entry with bit 1 set, gives a hit. `rsp_hit` and `rsp_fault` are never high together.
- R6: A fill of a pair not already present goes to the lowest-numbered invalid entry when one exists, and the replacement pointer still advances by one.
- R7: When every entry is valid, a fill of a new pair replaces the entry under the replacement pointer. The pointer then advances by one and wraps from the last entry to entry 0.
- R8: A fill of a pair already present overwrites that entry's physical page and rights, creates no second entry, and leaves the replacement pointer unchanged.
- R9: A single-entry invalidation removes only the entry matching both the given virtual page number and process identifier. If no entry matches, it has no effect.
- R10: A full flush invalidates every entry and returns the pointer to entry 0. A fill in the same cycle as a flush is discarded.
- R11: On a miss, `rsp_ppn` and `rsp_perm` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_pid | input | PID_W | Lookup process identifier |
| lk_write | input | 1 | Lookup is a write access |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_fault | output | 1 | Translation found but write not permitted |
| rsp_ppn | output | PPN_W | Physical page number (zero on miss) |
| rsp_perm | output | PERM_W | Access-right bits (bit 1 = write; zero on miss) |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_pid | input | PID_W | Process identifier to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_perm | input | PERM_W | Access-right bits to install |
| inv_one | input | 1 | Invalidate one entry this cycle |
| inv_vpn | input | VPN_W | Virtual page number to invalidate |
| inv_pid | input | PID_W | Process identifier to invalidate |
| inv_all | input | 1 | Invalidate every entry this cycle |

## Verification
A wrong valid bit shows at the ports on the next lookup of that pair, as a hit that should be a miss or the reverse. A replacement pointer that is off by one stays hidden until the buffer is full. Then the next new fill evicts the wrong neighbour, and the bench checks for this by looking up both neighbours of the expected victim straight after the fill. A duplicate entry left by a bad rewrite shows as a stale physical page, or as two entries answering one lookup. The bench reads the page back at once, and the match vector is checked as one-hot in every cycle.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  // Access-right field layout shared by the buffer and its users.
  localparam int PERM_W  = 3;
  localparam int PERM_WR = 1;   // write-permission bit

  // A write to a page whose write bit is clear is a protection fault.
  function automatic logic write_denied(input logic is_write,
                                        input logic [PERM_W-1:0] rights);
    return is_write && !rights[PERM_WR];
  endfunction
endpackage

// File: rtl/tlbx_cam.sv
// Parallel compare of one key against every stored tag pair.
module tlbx_cam #(
  parameter int N     = 16,
  parameter int IW    = 4,
  parameter int VPN_W = 20,
  parameter int PID_W = 8
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][VPN_W-1:0] tag_vpn,
  input  logic [N-1:0][PID_W-1:0] tag_pid,
  input  logic [VPN_W-1:0]        key_vpn,
  input  logic [PID_W-1:0]        key_pid,
  output logic [N-1:0]            hit_vec,
  output logic                    any_hit,
  output logic [IW-1:0]           hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tag_vpn[g] == key_vpn) && (tag_pid[g] == key_pid);
  end

  assign any_hit = |hit_vec;

  // Entries are unique, so an OR of matching indices encodes the hit.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
  end
endmodule

// File: rtl/tlbx_victim.sv
// Picks the slot for a new translation: lowest invalid, else the pointer.
module tlbx_victim #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  valid,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] slot,
  output logic          has_free
);
  always_comb begin
    slot     = ptr;
    has_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        slot     = IW'(i);
        has_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_one,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [PID_W-1:0]  inv_pid,
  input  logic              inv_all
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [IW-1:0] step_ptr(input logic [IW-1:0] p);
    return (p == IW'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  // Entry storage
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PID_W-1:0]  pid_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;
  logic [IW-1:0]                  ptr_q;

  // Named internal events
  logic [ENTRIES-1:0] lk_hits, fill_hits, inv_hits;
  logic               lk_any, fill_dup, inv_any;
  logic [IW-1:0]      lk_idx, fill_idx, inv_idx;
  logic [IW-1:0]      victim_slot, fill_slot;
  logic               has_free;
  logic               lk_denied;
  logic               fill_new;

  tlbx_cam #(.N(ENTRIES), .IW(IW), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_lk (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_pid(pid_q),
    .key_vpn(lk_vpn), .key_pid(lk_pid),
    .hit_vec(lk_hits), .any_hit(lk_any), .hit_idx(lk_idx));

  tlbx_cam #(.N(ENTRIES), .IW(IW), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_fill (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_pid(pid_q),
    .key_vpn(fill_vpn), .key_pid(fill_pid),
    .hit_vec(fill_hits), .any_hit(fill_dup), .hit_idx(fill_idx));

  tlbx_cam #(.N(ENTRIES), .IW(IW), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_inv (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_pid(pid_q),
    .key_vpn(inv_vpn), .key_pid(inv_pid),
    .hit_vec(inv_hits), .any_hit(inv_any), .hit_idx(inv_idx));

  tlbx_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .valid(valid_q), .ptr(ptr_q), .slot(victim_slot), .has_free(has_free));

  assign fill_slot = fill_dup ? fill_idx : victim_slot;
  assign fill_new  = fill_valid && !inv_all && !fill_dup;
  assign lk_denied = write_denied(lk_write, perm_q[lk_idx]);

  // Contents and replacement pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      vpn_q   <= '0;
      pid_q   <= '0;
      ppn_q   <= '0;
      perm_q  <= '0;
      ptr_q   <= '0;
    end else if (inv_all) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (inv_one && inv_any) valid_q[inv_idx] <= 1'b0;
      if (fill_valid) begin
        valid_q[fill_slot] <= 1'b1;
        vpn_q[fill_slot]   <= fill_vpn;
        pid_q[fill_slot]   <= fill_pid;
        ppn_q[fill_slot]   <= fill_ppn;
        perm_q[fill_slot]  <= fill_perm;
        if (!fill_dup) ptr_q <= step_ptr(ptr_q);
      end
    end
  end

  // Registered lookup answer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_any && !lk_denied;
      rsp_fault <= lk_valid && lk_any && lk_denied;
      rsp_ppn   <= (lk_valid && lk_any) ? ppn_q[lk_idx]  : '0;
      rsp_perm  <= (lk_valid && lk_any) ? perm_q[lk_idx] : '0;
    end
  end

  // Assertions
  a_r8_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));
  a_r5_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));
  a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_quiet_next: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fill_new |=> ptr_q == step_ptr($past(ptr_q)));
  a_r8_dup_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_dup && !inv_all) |=> $stable(ptr_q));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0 && ptr_q == '0));
  a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !rsp_fault) |-> (rsp_ppn == '0 && rsp_perm == '0));
  a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one && inv_any && !inv_all && !(fill_valid && fill_slot == inv_idx))
      |=> !valid_q[$past(inv_idx)]);
endmodule

// File: tb/tlbx_top_bench.sv
`timescale 1ns/1ps
module tlbx_top_bench;
  localparam int VPN_W = 20, PPN_W = 20, PID_W = 8, PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [PID_W-1:0] lk_pid = '0;
  logic rsp_valid, rsp_hit, rsp_fault;
  logic [PPN_W-1:0] rsp_ppn;
  logic [PW-1:0] rsp_perm;
  logic fill_valid = 0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PID_W-1:0] fill_pid = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [PW-1:0] fill_perm = '0;
  logic inv_one = 0, inv_all = 0;
  logic [VPN_W-1:0] inv_vpn = '0;
  logic [PID_W-1:0] inv_pid = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlbx_top u_tlbx_top (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .inv_one(inv_one), .inv_vpn(inv_vpn), .inv_pid(inv_pid), .inv_all(inv_all));

  // Bench's own mapping from a (page, process) pair to a physical page.
  function automatic logic [PPN_W-1:0] map_of(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p);
    return {v[11:0], p};
  endfunction

  task automatic expect_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                         input logic [PPN_W-1:0] ppn, input logic [PW-1:0] perm);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_pid = p; fill_ppn = ppn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  task automatic do_inv(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p);
    @(negedge clk); inv_one = 1; inv_vpn = v; inv_pid = p;
    @(negedge clk); inv_one = 0;
  endtask

  // Lookup and check the answer one cycle later.
  task automatic probe(input string req, input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                       input logic wr, input logic eh, input logic ef,
                       input logic [PPN_W-1:0] eppn, input logic [PW-1:0] eperm);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_pid = p; lk_write = wr;
    @(negedge clk);
    lk_valid = 0; lk_write = 0;
    expect_eq(req, "rsp_valid", 32'(rsp_valid), 1);
    expect_eq(req, "rsp_hit", 32'(rsp_hit), 32'(eh));
    expect_eq(req, "rsp_fault", 32'(rsp_fault), 32'(ef));
    expect_eq(req, "rsp_ppn", 32'(rsp_ppn), 32'(eppn));
    expect_eq(req, "rsp_perm", 32'(rsp_perm), 32'(eperm));
  endtask

  task automatic hit_rd(input string req, input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p);
    probe(req, v, p, 0, 1, 0, map_of(v, p), 3'b111);
  endtask

  task automatic miss_rd(input string req, input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p);
    probe(req, v, p, 0, 0, 0, '0, '0);
  endtask

  task automatic t_reset();
    expect_eq("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    miss_rd("R1", 20'h1, 8'h1);
    miss_rd("R11", 20'h0, 8'h0);
  endtask

  task automatic t_basic();
    do_fill(20'h100, 8'h3, 20'h777, 3'b011);
    probe("R3", 20'h100, 8'h3, 0, 1, 0, 20'h777, 3'b011);
    probe("R3", 20'h101, 8'h3, 0, 0, 0, '0, '0);
    @(negedge clk);
    expect_eq("R2", "rsp_valid idle", 32'(rsp_valid), 0);
  endtask

  task automatic t_pid();
    miss_rd("R4", 20'h100, 8'h4);
    do_fill(20'h100, 8'h4, 20'h888, 3'b111);
    probe("R4", 20'h100, 8'h4, 0, 1, 0, 20'h888, 3'b111);
    probe("R4", 20'h100, 8'h3, 0, 1, 0, 20'h777, 3'b011);
  endtask

  task automatic t_perm();
    do_fill(20'h200, 8'h3, 20'h222, 3'b001);
    probe("R5", 20'h200, 8'h3, 1, 0, 1, 20'h222, 3'b001);
    probe("R5", 20'h200, 8'h3, 0, 1, 0, 20'h222, 3'b001);
    probe("R5", 20'h100, 8'h3, 1, 1, 0, 20'h777, 3'b011);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h300; fill_pid = 8'h1;
    fill_ppn = map_of(20'h300, 8'h1); fill_perm = 3'b111;
    lk_valid = 1; lk_vpn = 20'h300; lk_pid = 8'h1; lk_write = 0;
    @(negedge clk);
    fill_valid = 0; lk_valid = 0;
    expect_eq("R2", "same-cycle lookup hit", 32'(rsp_hit), 0);
    hit_rd("R2", 20'h300, 8'h1);
  endtask

  task automatic t_dup();
    do_flush();
    do_fill(20'h10, 8'h1, 20'h11111, 3'b111);
    do_fill(20'h10, 8'h1, 20'h22222, 3'b101);
    probe("R8", 20'h10, 8'h1, 0, 1, 0, 20'h22222, 3'b101);
    for (int i = 1; i < 16; i++) do_fill(20'h10 + 20'(i), 8'h1, map_of(20'h10 + 20'(i), 8'h1), 3'b111);
    do_fill(20'h40, 8'h1, map_of(20'h40, 8'h1), 3'b111);
    miss_rd("R8", 20'h10, 8'h1);
    hit_rd("R8", 20'h11, 8'h1);
    hit_rd("R7", 20'h40, 8'h1);
  endtask

  task automatic t_flush();
    @(negedge clk);
    inv_all = 1; fill_valid = 1; fill_vpn = 20'h50; fill_pid = 8'h1;
    fill_ppn = map_of(20'h50, 8'h1); fill_perm = 3'b111;
    @(negedge clk);
    inv_all = 0; fill_valid = 0;
    miss_rd("R10", 20'h50, 8'h1);
    miss_rd("R10", 20'h11, 8'h1);
  endtask

  task automatic t_repl();
    do_flush();
    for (int i = 0; i < 16; i++) do_fill(20'h60 + 20'(i), 8'h1, map_of(20'h60 + 20'(i), 8'h1), 3'b111);
    hit_rd("R6", 20'h6F, 8'h1);
    do_fill(20'h70, 8'h1, map_of(20'h70, 8'h1), 3'b111);
    miss_rd("R7", 20'h60, 8'h1);
    hit_rd("R7", 20'h61, 8'h1);
    do_fill(20'h71, 8'h1, map_of(20'h71, 8'h1), 3'b111);
    miss_rd("R7", 20'h61, 8'h1);
    hit_rd("R7", 20'h62, 8'h1);
  endtask

  task automatic t_inv();
    do_inv(20'h65, 8'h1);
    miss_rd("R9", 20'h65, 8'h1);
    hit_rd("R9", 20'h64, 8'h1);
    do_inv(20'h66, 8'h9);
    hit_rd("R9", 20'h66, 8'h1);
    do_fill(20'h72, 8'h1, map_of(20'h72, 8'h1), 3'b111);
    hit_rd("R6", 20'h62, 8'h1);
    hit_rd("R6", 20'h72, 8'h1);
    do_fill(20'h73, 8'h1, map_of(20'h73, 8'h1), 3'b111);
    miss_rd("R6", 20'h63, 8'h1);
    hit_rd("R6", 20'h62, 8'h1);
    hit_rd("R6", 20'h73, 8'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_pid();
    t_perm();
    t_same_cycle();
    t_dup();
    t_flush();
    t_repl();
    t_inv();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule